// File: doc/BRIEF.md
# Preconfigured Virtual-Channel Mesh Router Node

This block is a single node of a two-dimensional mesh of routers. It has five port pairs: four toward the neighbouring nodes (north, east, south, west) and one toward the local processor. The east output of a node is wired to the west input of the node to its east, and the other directions pair up the same way. Words carry no routing header. Each word arrives with a virtual-channel number. A connection table, loaded before traffic starts, maps the pair (input side, virtual channel) to an output side and the virtual-channel number the word carries on that output. A path that ends at this node maps to the local side.

Each input side feeds four queues, one for each other side, so every queue is tagged with the side its words will leave from. A scheduler on each output shares the link among the queues that have words, in round-robin order. The channel width factor is set by a two-bit mode and limits how many virtual channels each side may use. Words on a virtual channel with no usable table entry are discarded and raise a sticky error flag.

All data ports use valid/ready. A word moves on a cycle where valid and ready are both high at the rising clock edge. An output keeps valid, data and virtual channel stable until ready is seen. An input drops ready when its pipeline and the queue ahead are full. No word is overwritten and none is lost. Ready never depends on valid in the same cycle.

Top module: `mesh_vc_router`

## Requirements
- R1: Reset clears every output valid and the error flag, raises idle, and raises all five input readies.
- R2: Side codes are north=0, east=1, south=2, west=3, local=4. A word accepted on side S with virtual channel V, where the table entry (S,V) is enabled with destination side D and destination channel C, leaves on output D with channel C and its data unchanged. No other output carries it.
- R3: With no contention, a word accepted at clock edge t appears on its output after edge t+3, and not earlier.
- R4: Mode m (0 to 3) sets the channel width factor to 1<<m, so each side may use 4<<m virtual channels (4, 8, 16 or 32). A word with a channel number at or above that limit is treated as having no table entry.
- R5: A word whose entry is disabled, whose entry points back to its own input side, or whose channel is out of range is discarded and appears on no output. The error flag then rises and stays high until reset.
- R6: A table write (cfg_we high at a clock edge) takes effect only while idle is high. A write issued while any word is in flight is ignored.
- R7: An output that is valid and not ready keeps valid, data and channel unchanged into the next cycle.
- R8: Nothing is dropped under backpressure and order is kept. With one output stalled, a single input feeding it accepts exactly QDEPTH+3 words (5 with default parameters) before its ready falls. All of them come out in order once the stall is released.
- R9: When two input sides stream into the same output at once, that output serves them alternately.
- R10: Idle is high exactly when no word is held anywhere in the router. While idle is high, every input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cwf_mode | input | 2 | Channel width factor select (factor = 1<<mode) |
| cfg_we | input | 1 | Table write strobe, honoured only while idle |
| cfg_side | input | 3 | Input side of the entry being written |
| cfg_vc | input | VCW | Input virtual channel of the entry being written |
| cfg_en | input | 1 | Entry enable |
| cfg_dst | input | 3 | Destination side stored in the entry |
| cfg_dvc | input | VCW | Outgoing virtual channel stored in the entry |
| in_valid | input | 5 | Word offered, one bit per side |
| in_ready | output | 5 | Side can take a word |
| in_vc | input | 5*VCW | Virtual channel per side, side s at bits s*VCW |
| in_data | input | 5*DW | Data per side, side s at bits s*DW |
| out_valid | output | 5 | Word present, one bit per side |
| out_ready | input | 5 | Downstream takes the word |
| out_vc | output | 5*VCW | Outgoing virtual channel per side |
| out_data | output | 5*DW | Outgoing data per side |
| idle | output | 1 | Nothing in flight |
| err | output | 1 | Sticky flag for discarded words |

## Verification
The bound checker checks on every cycle that a stalled output holds still, that the error flag never clears once set, that an idle router is ready on every side, and that no output fires within three cycles of reset. Routing correctness, the exact three-cycle latency, the mode limit, the refusal of table writes while busy, the capacity and ordering under stall, and the alternation between competing inputs all depend on the contents of the table and on sequences of words. Only the bench scenarios can show those: a sweep over every input and output pair, and directed stall and contention runs.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
  localparam int NSIDE = 5;
  localparam int SW    = 3;

  localparam logic [SW-1:0] SIDE_N = 3'd0;
  localparam logic [SW-1:0] SIDE_E = 3'd1;
  localparam logic [SW-1:0] SIDE_S = 3'd2;
  localparam logic [SW-1:0] SIDE_W = 3'd3;
  localparam logic [SW-1:0] SIDE_L = 3'd4;
endpackage

// File: rtl/mvr_fifo.sv
module mvr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign dout    = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (do_pop)
        rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mvr_cfg_table.sv
module mvr_cfg_table import mvr_pkg::*; #(
  parameter int VC_MAX = 32,
  parameter int VCW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SW-1:0]         wside,
  input  logic [VCW-1:0]        wvc,
  input  logic                  wen,
  input  logic [SW-1:0]         wdst,
  input  logic [VCW-1:0]        wdvc,
  input  logic [NSIDE*VCW-1:0]  lk_vc,
  output logic [NSIDE-1:0]      lk_hit,
  output logic [NSIDE*SW-1:0]   lk_dst,
  output logic [NSIDE*VCW-1:0]  lk_dvc
);
  logic           ent_v [NSIDE][VC_MAX];
  logic [SW-1:0]  ent_d [NSIDE][VC_MAX];
  logic [VCW-1:0] ent_c [NSIDE][VC_MAX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSIDE; s++)
        for (int v = 0; v < VC_MAX; v++)
          ent_v[s][v] <= 1'b0;
    end else if (we && (int'(wside) < NSIDE)) begin
      ent_v[wside][wvc] <= wen;
      ent_d[wside][wvc] <= wdst;
      ent_c[wside][wvc] <= wdvc;
    end
  end

  // A usable entry must name an existing side other than the one it came in on.
  always_comb begin
    for (int s = 0; s < NSIDE; s++) begin
      logic [VCW-1:0] vc;
      logic [SW-1:0]  d;
      vc = lk_vc[s*VCW +: VCW];
      d  = ent_d[s][vc];
      lk_hit[s]              = ent_v[s][vc] && (d != SW'(s)) && (int'(d) < NSIDE);
      lk_dst[s*SW +: SW]     = d;
      lk_dvc[s*VCW +: VCW]   = ent_c[s][vc];
    end
  end
endmodule

// File: rtl/mvr_in_stage.sv
module mvr_in_stage import mvr_pkg::*; #(
  parameter int DW  = 16,
  parameter int VCW = 5,
  localparam int QW = DW + VCW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VCW:0]     vc_lim,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VCW-1:0]   in_vc,
  input  logic [DW-1:0]    in_data,
  output logic [VCW-1:0]   lk_vc,
  input  logic             lk_hit,
  input  logic [SW-1:0]    lk_dst,
  input  logic [VCW-1:0]   lk_dvc,
  input  logic [NSIDE-1:0] q_full,
  output logic [NSIDE-1:0] q_push,
  output logic [QW-1:0]    q_word,
  output logic             drop,
  output logic             busy
);
  // stage 0: captured word
  logic           v0;
  logic [VCW-1:0] c0;
  logic [DW-1:0]  d0;
  // stage 1: word with its table result
  logic           v1, h1;
  logic [SW-1:0]  t1;
  logic [VCW-1:0] dv1;
  logic [DW-1:0]  d1;

  logic hit0, tgt_full, free1;

  assign lk_vc = c0;
  assign hit0  = lk_hit && ({1'b0, c0} < vc_lim);

  always_comb begin
    tgt_full = 1'b1;
    for (int o = 0; o < NSIDE; o++)
      if (t1 == SW'(o)) tgt_full = q_full[o];
  end

  assign free1    = !v1 || !h1 || !tgt_full;
  assign in_ready = !v0 || free1;
  assign drop     = v1 && !h1;
  assign busy     = v0 || v1;
  assign q_word   = {dv1, d1};

  always_comb begin
    for (int o = 0; o < NSIDE; o++)
      q_push[o] = v1 && h1 && (t1 == SW'(o)) && !q_full[o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0  <= 1'b0;
      c0  <= '0;
      d0  <= '0;
      v1  <= 1'b0;
      h1  <= 1'b0;
      t1  <= '0;
      dv1 <= '0;
      d1  <= '0;
    end else begin
      if (free1) begin
        v1  <= v0;
        h1  <= hit0;
        t1  <= lk_dst;
        dv1 <= lk_dvc;
        d1  <= d0;
      end
      if (in_ready) begin
        v0 <= in_valid;
        c0 <= in_vc;
        d0 <= in_data;
      end
    end
  end
endmodule

// File: rtl/mvr_out_port.sv
module mvr_out_port import mvr_pkg::*; #(
  parameter int DW  = 16,
  parameter int VCW = 5,
  localparam int QW = DW + VCW,
  localparam int PW = $clog2(NSIDE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSIDE-1:0]    req,
  input  logic [NSIDE*QW-1:0] words,
  output logic [NSIDE-1:0]    pop,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [VCW-1:0]      out_vc,
  output logic [DW-1:0]       out_data
);
  logic [PW-1:0] last;
  logic [PW-1:0] gidx;
  logic          found, load;

  // Round-robin: search starts one past the queue served last.
  always_comb begin
    found = 1'b0;
    gidx  = last;
    for (int k = 1; k <= NSIDE; k++) begin
      int idx;
      idx = (int'(last) + k) % NSIDE;
      if (!found && req[idx]) begin
        found = 1'b1;
        gidx  = PW'(idx);
      end
    end
  end

  assign load = !out_valid || out_ready;
  assign pop  = (load && found) ? (NSIDE'(1) << gidx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vc    <= '0;
      out_data  <= '0;
      last      <= PW'(NSIDE-1);
    end else if (load) begin
      out_valid <= found;
      if (found) begin
        {out_vc, out_data} <= words[gidx*QW +: QW];
        last <= gidx;
      end
    end
  end
endmodule

// File: rtl/mesh_vc_router.sv
module mesh_vc_router import mvr_pkg::*; #(
  parameter int DW          = 16,
  parameter int CWF_LOG_MAX = 3,
  parameter int QDEPTH      = 2,
  localparam int VC_MAX     = 4 << CWF_LOG_MAX,
  localparam int VCW        = $clog2(VC_MAX),
  localparam int QW         = DW + VCW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cwf_mode,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_side,
  input  logic [VCW-1:0]       cfg_vc,
  input  logic                 cfg_en,
  input  logic [2:0]           cfg_dst,
  input  logic [VCW-1:0]       cfg_dvc,
  input  logic [4:0]           in_valid,
  output logic [4:0]           in_ready,
  input  logic [5*VCW-1:0]     in_vc,
  input  logic [5*DW-1:0]      in_data,
  output logic [4:0]           out_valid,
  input  logic [4:0]           out_ready,
  output logic [5*VCW-1:0]     out_vc,
  output logic [5*DW-1:0]      out_data,
  output logic                 idle,
  output logic                 err
);
  logic [1:0]   mode_eff;
  logic [VCW:0] vc_lim;

  assign mode_eff = (int'(cwf_mode) > CWF_LOG_MAX) ? 2'(CWF_LOG_MAX) : cwf_mode;
  assign vc_lim   = (VCW+1)'(4) << mode_eff;

  logic [NSIDE*VCW-1:0] lk_vc;
  logic [NSIDE-1:0]     lk_hit;
  logic [NSIDE*SW-1:0]  lk_dst;
  logic [NSIDE*VCW-1:0] lk_dvc;

  logic [NSIDE-1:0] q_full_m  [NSIDE];   // [in][out]
  logic [NSIDE-1:0] q_empty_m [NSIDE];   // [in][out]
  logic [QW-1:0]    q_dout_m  [NSIDE][NSIDE];
  logic [NSIDE-1:0] push_m    [NSIDE];   // [in][out]
  logic [NSIDE-1:0] pop_m     [NSIDE];   // [out][in]
  logic [NSIDE-1:0] req_m     [NSIDE];   // [out][in]
  logic [NSIDE*QW-1:0] wrd_m  [NSIDE];   // [out]
  logic [QW-1:0]    qw        [NSIDE];
  logic [NSIDE-1:0] drop_v, busy_v;
  logic             all_empty;

  mvr_cfg_table #(.VC_MAX(VC_MAX), .VCW(VCW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we && idle),
    .wside(cfg_side), .wvc(cfg_vc), .wen(cfg_en), .wdst(cfg_dst), .wdvc(cfg_dvc),
    .lk_vc(lk_vc), .lk_hit(lk_hit), .lk_dst(lk_dst), .lk_dvc(lk_dvc)
  );

  for (genvar i = 0; i < NSIDE; i++) begin : g_in
    mvr_in_stage #(.DW(DW), .VCW(VCW)) u_in (
      .clk(clk), .rst_n(rst_n), .vc_lim(vc_lim),
      .in_valid(in_valid[i]), .in_ready(in_ready[i]),
      .in_vc(in_vc[i*VCW +: VCW]), .in_data(in_data[i*DW +: DW]),
      .lk_vc(lk_vc[i*VCW +: VCW]), .lk_hit(lk_hit[i]),
      .lk_dst(lk_dst[i*SW +: SW]), .lk_dvc(lk_dvc[i*VCW +: VCW]),
      .q_full(q_full_m[i]), .q_push(push_m[i]), .q_word(qw[i]),
      .drop(drop_v[i]), .busy(busy_v[i])
    );

    for (genvar o = 0; o < NSIDE; o++) begin : g_q
      if (i != o) begin : g_fifo
        mvr_fifo #(.W(QW), .DEPTH(QDEPTH)) u_q (
          .clk(clk), .rst_n(rst_n),
          .push(push_m[i][o]), .din(qw[i]), .full(q_full_m[i][o]),
          .pop(pop_m[o][i]), .dout(q_dout_m[i][o]), .empty(q_empty_m[i][o])
        );
      end else begin : g_none
        assign q_full_m[i][o]  = 1'b1;
        assign q_empty_m[i][o] = 1'b1;
        assign q_dout_m[i][o]  = '0;
      end
      assign req_m[o][i]          = !q_empty_m[i][o];
      assign wrd_m[o][i*QW +: QW] = q_dout_m[i][o];
    end
  end

  for (genvar o = 0; o < NSIDE; o++) begin : g_out
    mvr_out_port #(.DW(DW), .VCW(VCW)) u_out (
      .clk(clk), .rst_n(rst_n), .req(req_m[o]), .words(wrd_m[o]), .pop(pop_m[o]),
      .out_ready(out_ready[o]), .out_valid(out_valid[o]),
      .out_vc(out_vc[o*VCW +: VCW]), .out_data(out_data[o*DW +: DW])
    );
  end

  always_comb begin
    all_empty = 1'b1;
    for (int i = 0; i < NSIDE; i++)
      if (!(&q_empty_m[i])) all_empty = 1'b0;
  end

  assign idle = all_empty && !(|busy_v) && !(|out_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (|drop_v) err <= 1'b1;
  end
endmodule

// File: rtl/mvr_chk.sv
module mvr_chk #(
  parameter int DW  = 16,
  parameter int VCW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       out_valid,
  input logic [4:0]       out_ready,
  input logic [5*VCW-1:0] out_vc,
  input logic [5*DW-1:0]  out_data,
  input logic [4:0]       in_ready,
  input logic             idle,
  input logic             err
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  for (genvar s = 0; s < 5; s++) begin : g_side
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[s] && !out_ready[s] |=> out_valid[s] && $stable(out_data[s*DW +: DW]) && $stable(out_vc[s*VCW +: VCW]))
      else $error("output %0d changed while stalled", s); // R7
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err)
    else $error("error flag cleared"); // R5

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (in_ready == 5'h1f))
    else $error("idle router refused input"); // R10

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> (out_valid == 5'h00))
    else $error("output before three cycles"); // R3
endmodule

bind mesh_vc_router mvr_chk #(.DW(DW), .VCW(VCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_vc(out_vc), .out_data(out_data), .in_ready(in_ready), .idle(idle), .err(err)
);

// File: tb/sim_mesh_vc_router.sv
module sim_mesh_vc_router;
  localparam int DW  = 16;
  localparam int VCW = 5;
  localparam int QD  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [1:0]       cwf_mode;
  logic             cfg_we, cfg_en;
  logic [2:0]       cfg_side, cfg_dst;
  logic [VCW-1:0]   cfg_vc, cfg_dvc;
  logic [4:0]       in_valid, in_ready, out_valid, out_ready;
  logic [5*VCW-1:0] in_vc, out_vc;
  logic [5*DW-1:0]  in_data, out_data;
  logic             idle, err;

  mesh_vc_router u0 (
    .clk(clk), .rst_n(rst_n), .cwf_mode(cwf_mode),
    .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_vc(cfg_vc), .cfg_en(cfg_en),
    .cfg_dst(cfg_dst), .cfg_dvc(cfg_dvc),
    .in_valid(in_valid), .in_ready(in_ready), .in_vc(in_vc), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_vc(out_vc), .out_data(out_data),
    .idle(idle), .err(err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; cwf_mode = m; cfg_we = 0; cfg_en = 0; cfg_side = 0; cfg_dst = 0;
    cfg_vc = 0; cfg_dvc = 0; in_valid = 0; in_vc = 0; in_data = 0; out_ready = 5'h1f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int s, input int vc, input bit en, input int d, input int dvc);
    @(negedge clk);
    cfg_we = 1; cfg_side = 3'(s); cfg_vc = VCW'(vc); cfg_en = en; cfg_dst = 3'(d); cfg_dvc = VCW'(dvc);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input int s, input int vc, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid[s] = 1'b1; in_vc[s*VCW +: VCW] = VCW'(vc); in_data[s*DW +: DW] = d;
    chk(in_ready[s] == 1'b1, "R8 ready before single send", in_ready[s], 1);
    @(negedge clk);
    in_valid[s] = 1'b0;
  endtask

  task automatic await_out(input int o, output int n);
    n = 0;
    while (n < 8 && !out_valid[o]) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic watch_quiet(input int cycles, output bit any);
    any = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (|out_valid) any = 1;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    bit any;

    // R1: reset state
    do_reset(2'd3);
    chk(out_valid == 5'h00, "R1 out_valid", out_valid, 0);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(in_ready == 5'h1f, "R1 in_ready", in_ready, 5'h1f);

    // R2, R3: every input/output pair, including local delivery
    for (int i = 0; i < 5; i++) begin
      for (int o = 0; o < 5; o++) begin
        if (i != o) begin
          int vc;
          logic [DW-1:0] d;
          vc = i * 5 + o;
          d  = 16'hA000 + 16'(i * 16 + o);
          cfg(i, vc, 1, o, 31 - vc);
          send(i, vc, d);
          await_out(o, n);
          chk(n == 3, "R3 latency", n, 3);
          chk(out_data[o*DW +: DW] == d, "R2 data", out_data[o*DW +: DW], d);
          chk(out_vc[o*VCW +: VCW] == VCW'(31 - vc), "R2 outgoing vc", out_vc[o*VCW +: VCW], 31 - vc);
          chk(out_valid == (5'h01 << o), "R2 only target output", out_valid, 5'h01 << o);
        end
      end
    end
    chk(err == 1'b0, "R5 no error on good traffic", err, 0);

    // R4: mode 0 allows channels 0..3 only
    do_reset(2'd0);
    cfg(3, 2, 1, 1, 8);
    cfg(3, 6, 1, 1, 9);
    send(3, 2, 16'h1234);
    await_out(1, n);
    chk(n == 3 && out_data[DW +: DW] == 16'h1234, "R4 in-range channel delivered", out_data[DW +: DW], 16'h1234);
    send(3, 6, 16'h5678);
    watch_quiet(8, any);
    chk(!any, "R4 out-of-range channel blocked", any, 0);
    chk(err == 1'b1, "R4 out-of-range raises err", err, 1);

    // R5: unconfigured channel and u-turn entry
    do_reset(2'd3);
    send(0, 7, 16'h0BAD);
    watch_quiet(8, any);
    chk(!any, "R5 unconfigured dropped", any, 0);
    chk(err == 1'b1, "R5 err set", err, 1);
    cfg(1, 9, 1, 4, 3);
    send(1, 9, 16'h00AA);
    await_out(4, n);
    chk(err == 1'b1, "R5 err sticky after good word", err, 1);
    do_reset(2'd3);
    cfg(2, 4, 1, 2, 0);
    send(2, 4, 16'h0CCC);
    watch_quiet(8, any);
    chk(!any && err == 1'b1, "R5 u-turn dropped", {any, err}, 1);

    // R6, R10: table writes ignored while busy
    do_reset(2'd3);
    cfg(1, 3, 1, 4, 5);
    out_ready[4] = 1'b0;
    send(1, 3, 16'h7777);
    repeat (6) @(negedge clk);
    chk(idle == 1'b0, "R10 busy while word parked", idle, 0);
    cfg(0, 1, 1, 2, 2);
    out_ready[4] = 1'b1;
    await_out(4, n);
    chk(out_data[4*DW +: DW] == 16'h7777, "R6 parked word delivered", out_data[4*DW +: DW], 16'h7777);
    repeat (2) @(negedge clk);
    chk(idle == 1'b1, "R10 idle after drain", idle, 1);
    send(0, 1, 16'h2222);
    watch_quiet(8, any);
    chk(!any && err == 1'b1, "R6 write during busy ignored", {any, err}, 1);

    // R7, R8: stall capacity, hold, order
    do_reset(2'd3);
    cfg(3, 0, 1, 1, 12);
    out_ready[1] = 1'b0;
    begin
      int acc;
      int got;
      acc = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        in_valid[3] = 1'b1; in_vc[3*VCW +: VCW] = '0;
        in_data[3*DW +: DW] = 16'h0100 + 16'(acc);
        if (in_ready[3]) acc++;
      end
      @(negedge clk);
      in_valid[3] = 1'b0;
      chk(acc == QD + 3, "R8 accepted before stall", acc, QD + 3);
      chk(out_valid[1] && out_data[DW +: DW] == 16'h0100, "R7 head word shown", out_data[DW +: DW], 16'h0100);
      @(negedge clk);
      chk(out_valid[1] && out_data[DW +: DW] == 16'h0100 && out_vc[VCW +: VCW] == 5'd12,
          "R7 head word held", out_data[DW +: DW], 16'h0100);
      out_ready[1] = 1'b1;
      got = 0;
      for (int k = 0; k < 20; k++) begin
        if (out_valid[1]) begin
          chk(out_data[DW +: DW] == 16'h0100 + 16'(got), "R8 order", out_data[DW +: DW], 16'h0100 + got);
          got++;
        end
        @(negedge clk);
      end
      chk(got == QD + 3, "R8 none lost", got, QD + 3);
    end

    // R9: two inputs contending for east
    do_reset(2'd3);
    cfg(3, 1, 1, 1, 20);
    cfg(0, 2, 1, 1, 21);
    begin
      int cw, cn, got, alt_bad;
      logic [3:0] prev;
      cw = 0; cn = 0; got = 0; alt_bad = 0; prev = 4'h0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (out_valid[1]) begin
          logic [3:0] src;
          src = out_data[DW+12 +: 4];
          if (got > 0 && src == prev) alt_bad++;
          prev = src;
          got++;
        end
        in_valid[3] = (cw < 6);
        in_vc[3*VCW +: VCW] = 5'd1;
        in_data[3*DW +: DW] = 16'h3000 + 16'(cw);
        if (cw < 6 && in_ready[3]) cw++;
        in_valid[0] = (cn < 6);
        in_vc[0 +: VCW] = 5'd2;
        in_data[0 +: DW] = 16'h4000 + 16'(cn);
        if (cn < 6 && in_ready[0]) cn++;
      end
      chk(got == 12, "R9 all contending words delivered", got, 12);
      chk(alt_bad == 0, "R9 alternation", alt_bad, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule